// File: doc/BRIEF.md
# Synchronous Serial Transceiver

This block is a full-duplex synchronous serial port. In each frame it shifts a word out on its data output and, in the same frames of shift clock, shifts a word in from its data input. Software sets the frame length, bit order, clock idle level and clock phase. It fills a transmit holding register and reads completed words from a receive register. Words are always right-aligned in both registers. As master, the block makes the shift clock from a reload divider of the module clock. As slave, it follows a shift clock from outside, brought in through a synchronizer.

The transmit holding register feeds the shift register as soon as the shift register is free. If software refills the holding register during a frame, the next frame follows the current one with no idle gap, and the busy flag stays up across the join. A one-cycle transmit request marks each load and a one-cycle receive request marks each completed frame. Writing the holding register while it still holds an unloaded word replaces that word and raises a sticky collision flag.

Top module: `sst_top`

## Requirements
- R1: The width field is control bits [3:0] and holds the frame length minus one. Values 1 to 15 select 2 to 16 bits, and 0 selects 2 bits. Each frame shifts exactly that many bits out and that many bits in.
- R2: Control bit 4 sets the bit order: 0 sends and receives LSB first, 1 sends and receives MSB first.
- R3: Data is right-aligned in both registers: frame bit 0 is register bit 0. Transmit register bits at or above the frame length are never sent. Receive register bits at or above the frame length carry no meaning.
- R4: Writing address 1 while idle loads the word into the shift register one cycle later. In that same cycle a one-cycle tx_irq pulse is raised and busy (control read bit 9) goes high. As master (control bit 7 = 1) the clock starts without any further action.
- R5: After the last bit, the received word appears at read address 1 and rx_irq pulses for one cycle. If no word is waiting, busy reads 0 in that same cycle.
- R6: A word written during a frame starts its own frame at the end of the current one. The shift clock keeps its half-period unbroken across the join, and busy never drops between the two frames.
- R7: Control bit 5 sets the idle level of the shift clock. Control bit 6 sets the phase. With phase 0, data is sampled on the leading edge and changes on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: As master, every half-period of the shift clock lasts reload+1 module clocks. The reload value is written at address 2.
- R9: As slave (control bit 7 = 0), a loaded word waits, with busy high and no frame completing, until an external shift clock arrives. The external clock needs at least four module clocks per half-period.
- R10: Writing address 1 while an unloaded word is still held replaces that word and sets the collision flag (control read bit 10). Writing control with bit 8 = 1 clears the flag.
- R11: Busy cannot be written: a control write with bit 9 set leaves busy at 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 data, 2 reload |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| tx_irq | output | 1 | One-cycle pulse when a word is loaded for shifting |
| rx_irq | output | 1 | One-cycle pulse when a frame completes |
| sclk_in | input | 1 | External shift clock for slave mode |
| sclk_out | output | 1 | Shift clock driven in master mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with its default 16-bit reload divider and two synchronizer stages. It programs reload values of 0 to 3, so master frames of every length finish within tens of cycles. Reload 0 gives a one-clock half-period in loopback, which checks that the master samples its data input without the synchronizer delay. Two synchronizer stages keep the external clock of the slave tests at a six-clock half-period, which is within the four-clock margin.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int FRAME_MAX = 16;
    localparam int WF_W      = $clog2(FRAME_MAX);

    typedef logic [FRAME_MAX-1:0] word_t;
    typedef logic [WF_W:0]        cnt_t;

    // control register image, bit 0 upward: width-1, order, idle level, phase, master
    typedef struct packed {
        logic            master;
        logic            cpha;
        logic            cpol;
        logic            msb_first;
        logic [WF_W-1:0] wlen_m1;
    } cfg_t;

    localparam int CFG_W    = $bits(cfg_t);
    localparam int CLR_BIT  = CFG_W;
    localparam int BUSY_BIT = CFG_W + 1;
    localparam int COLL_BIT = CFG_W + 2;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DATA = 2'd1,
        A_DIV  = 2'd2
    } addr_e;

    function automatic cnt_t frame_bits(cfg_t c);
        if (c.wlen_m1 == '0) return cnt_t'(2);
        return {1'b0, c.wlen_m1} + 1'b1;
    endfunction

    function automatic logic head_bit(word_t sr, cfg_t c);
        cnt_t top = frame_bits(c) - 1'b1;
        return c.msb_first ? sr[top[WF_W-1:0]] : sr[0];
    endfunction

    function automatic word_t tx_advance(word_t sr, logic msb);
        return msb ? (sr << 1) : (sr >> 1);
    endfunction

    function automatic word_t rx_insert(word_t sr, logic b, logic msb);
        return msb ? {sr[FRAME_MAX-2:0], b} : {b, sr[FRAME_MAX-1:1]};
    endfunction

    function automatic word_t rx_align(word_t sr, cfg_t c);
        return c.msb_first ? sr : (sr >> (cnt_t'(FRAME_MAX) - frame_bits(c)));
    endfunction

endpackage

// File: rtl/sst_edge_src.sv
module sst_edge_src
    import sst_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             master,
    input  logic             cpol,
    input  logic [DIV_W-1:0] reload,
    input  logic             sclk_in,
    input  logic             sdi,
    output logic             lead_ev,
    output logic             trail_ev,
    output logic             sclk_out,
    output logic             sdi_bit
);
    logic [DIV_W-1:0]     cnt;
    logic                 phase;
    logic                 run_m;
    logic                 tick;
    logic [SYNC_STAGES:0] ck_pipe;
    logic [SYNC_STAGES:0] dt_pipe;
    logic                 ck_new, ck_old, ext_rise, ext_fall;

    assign run_m = run & master;
    assign tick  = run_m && (cnt == '0);

    // master divider: held at reload while not shifting
    always_ff @(posedge clk) begin
        if (rst || !run_m) begin
            cnt   <= reload;
            phase <= 1'b0;
        end else if (cnt == '0) begin
            cnt   <= reload;
            phase <= ~phase;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // external clock and data synchronizer, extra stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
        end else begin
            ck_pipe[0] <= sclk_in;
            dt_pipe[0] <= sdi;
            for (int i = 1; i <= SYNC_STAGES; i++) begin
                ck_pipe[i] <= ck_pipe[i-1];
                dt_pipe[i] <= dt_pipe[i-1];
            end
        end
    end

    assign ck_new   = ck_pipe[SYNC_STAGES-1];
    assign ck_old   = ck_pipe[SYNC_STAGES];
    assign ext_rise = ck_new & ~ck_old;
    assign ext_fall = ~ck_new & ck_old;

    assign lead_ev  = (tick & ~phase) | (run & ~master & (cpol ? ext_fall : ext_rise));
    assign trail_ev = (tick &  phase) | (run & ~master & (cpol ? ext_rise : ext_fall));
    assign sclk_out = cpol ^ (master & phase);
    assign sdi_bit  = master ? sdi : dt_pipe[SYNC_STAGES-1];

    p_half_period_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && reload != '0 && $stable(reload)) |=> !tick);

    p_single_edge_r7: assert property (@(posedge clk) disable iff (rst)
        !(lead_ev && trail_ev));

    p_idle_phase_r8: assert property (@(posedge clk) disable iff (rst)
        !run_m |=> (sclk_out == cpol));

endmodule

// File: rtl/sst_shift_engine.sv
module sst_shift_engine
    import sst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  logic  load,
    input  word_t load_word,
    input  logic  lead_ev,
    input  logic  trail_ev,
    input  logic  sdi_bit,
    output logic  sdo,
    output logic  last_edge,
    output word_t rx_frame
);
    word_t tx_sr, rx_sr, rx_next;
    cnt_t  bcnt;
    logic  sample_ev, shift_ev;

    assign sample_ev = cfg.cpha ? trail_ev : lead_ev;
    assign shift_ev  = cfg.cpha ? lead_ev  : trail_ev;
    assign last_edge = trail_ev && (bcnt == frame_bits(cfg) - 1'b1);
    assign rx_next   = sample_ev ? rx_insert(rx_sr, sdi_bit, cfg.msb_first) : rx_sr;
    assign rx_frame  = rx_align(rx_next, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
            sdo   <= 1'b0;
            bcnt  <= '0;
        end else if (load) begin
            bcnt <= '0;
            if (cfg.cpha) begin
                tx_sr <= load_word;
            end else begin
                sdo   <= head_bit(load_word, cfg);
                tx_sr <= tx_advance(load_word, cfg.msb_first);
            end
        end else begin
            rx_sr <= rx_next;
            if (shift_ev && !(!cfg.cpha && last_edge)) begin
                sdo   <= head_bit(tx_sr, cfg);
                tx_sr <= tx_advance(tx_sr, cfg.msb_first);
            end
            if (trail_ev) bcnt <= last_edge ? '0 : bcnt + 1'b1;
        end
    end

    p_bit_count_range_r1: assert property (@(posedge clk) disable iff (rst)
        bcnt < frame_bits(cfg));

    p_load_restarts_count_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (bcnt == '0));

endmodule

// File: rtl/sst_top.sv
module sst_top
    import sst_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        tx_irq,
    output logic        rx_irq,
    input  logic        sclk_in,
    output logic        sclk_out,
    input  logic        sdi,
    output logic        sdo
);
    cfg_t             cfg;
    logic [DIV_W-1:0] reload;
    word_t            tbuf, rbuf, rx_frame;
    logic             tb_full, busy, coll;
    logic             start, last_edge, lead_ev, trail_ev, sdi_bit;
    logic             wr_ctrl, wr_data, wr_div;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_data = wr_en && (addr == A_DATA);
    assign wr_div  = wr_en && (addr == A_DIV);
    assign start   = tb_full && (!busy || last_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            reload  <= '0;
            tbuf    <= '0;
            rbuf    <= '0;
            tb_full <= 1'b0;
            busy    <= 1'b0;
            coll    <= 1'b0;
            tx_irq  <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            tx_irq <= start;
            rx_irq <= last_edge;
            if (last_edge) rbuf <= rx_frame;
            if (start)          busy <= 1'b1;
            else if (last_edge) busy <= 1'b0;

            if (wr_data) begin
                tbuf    <= wdata;
                tb_full <= 1'b1;
                if (tb_full && !start) coll <= 1'b1;
            end else if (start) begin
                tb_full <= 1'b0;
            end

            if (wr_ctrl) begin
                cfg <= cfg_t'(wdata[CFG_W-1:0]);
                if (wdata[CLR_BIT]) coll <= 1'b0;
            end
            if (wr_div) reload <= wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = 16'({coll, busy, 1'b0, cfg});
            A_DATA:  rdata = rbuf;
            A_DIV:   rdata = 16'(reload);
            default: rdata = '0;
        endcase
    end

    sst_edge_src #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk(clk), .rst(rst), .run(busy), .master(cfg.master), .cpol(cfg.cpol),
        .reload(reload), .sclk_in(sclk_in), .sdi(sdi),
        .lead_ev(lead_ev), .trail_ev(trail_ev), .sclk_out(sclk_out), .sdi_bit(sdi_bit)
    );

    sst_shift_engine u_engine (
        .clk(clk), .rst(rst), .cfg(cfg), .load(start), .load_word(tbuf),
        .lead_ev(lead_ev), .trail_ev(trail_ev), .sdi_bit(sdi_bit),
        .sdo(sdo), .last_edge(last_edge), .rx_frame(rx_frame)
    );

    p_busy_ends_with_rx_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rx_irq);

    p_tx_req_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> busy);

    p_rx_req_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    p_idle_clock_level_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk_out == cfg.cpol));

    p_collision_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (coll && !(wr_ctrl && wdata[CLR_BIT])) |=> coll);

endmodule

// File: tb/tb_sst_top.sv
module tb_sst_top;
    localparam int CLK_P = 10;
    localparam int HALF_EXT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tx_irq, rx_irq, sclk_out, sdo;
    logic        sclk_drv = 1'b0, sdi_drv = 1'b0, slave_mode = 1'b0;
    logic        sdi_w;

    assign sdi_w = slave_mode ? sdi_drv : sdo;

    sst_top #(.DIV_W(16), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_in(sclk_drv), .sclk_out(sclk_out),
        .sdi(sdi_w), .sdo(sdo)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, fails = 0;
    int rx_cnt = 0, tx_cnt = 0, wide_pulse = 0;
    logic rx_q = 1'b0, tx_q = 1'b0, sclk_q = 1'b0;
    bit   mon_on = 0, cpol_m = 0, cpha_m = 0, have_t = 0, busy_watch = 0;
    logic [31:0] cap_v;
    int cap_n = 0, cyc = 0, t_last = 0, gmin = 0, gmax = 0, busy_drop = 0, watch_until = 0;

    // observer, sampled a quarter period after the active edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rx_irq) rx_cnt++;
        if (tx_irq) tx_cnt++;
        if ((rx_irq && rx_q) || (tx_irq && tx_q)) wide_pulse++;
        rx_q = rx_irq;
        tx_q = tx_irq;
        if (mon_on && sclk_out !== sclk_q) begin
            if ((sclk_out != cpol_m) ^ cpha_m) begin
                cap_v[cap_n] = sdo;
                cap_n++;
            end
            if (have_t) begin
                if (cyc - t_last < gmin) gmin = cyc - t_last;
                if (cyc - t_last > gmax) gmax = cyc - t_last;
            end
            t_last = cyc;
            have_t = 1;
        end
        sclk_q = sclk_out;
        if (busy_watch && addr == 2'd0 && !rdata[9] && rx_cnt < watch_until) busy_drop++;
        cyc++;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic int fbits(int wm1);
        return (wm1 == 0) ? 2 : wm1 + 1;
    endfunction

    function automatic logic [31:0] lowmask(int w);
        return (32'd1 << w) - 32'd1;
    endfunction

    function automatic logic [31:0] assemble(int base, int w, bit msb);
        logic [31:0] g = '0;
        for (int i = 0; i < w; i++) begin
            if (msb) g[w-1-i] = cap_v[base+i];
            else     g[i]     = cap_v[base+i];
        end
        return g;
    endfunction

    task automatic wait_rx(int target);
        int n = 0;
        while (rx_cnt < target && n < 20000) begin
            @(negedge clk);
            n++;
        end
        #1;
    endtask

    task automatic arm_monitor(bit cpol, bit cpha);
        cpol_m = cpol; cpha_m = cpha;
        cap_n = 0; cap_v = '0; have_t = 0; gmin = 1000000; gmax = 0;
        mon_on = 1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        read_at(2'd0, v);
        check(v == 16'h0, "R11", "control/busy after reset", v, 16'h0);
        check({tx_irq, rx_irq, sclk_out, sdo} == 4'b0, "R4", "outputs after reset",
              {tx_irq, rx_irq, sclk_out, sdo}, 4'b0);
    endtask

    task automatic t_master(string req, bit cpol, bit cpha, bit msb, int wm1, int rl, logic [15:0] d);
        int w = fbits(wm1);
        int base;
        logic [15:0] v;
        slave_mode = 1'b0;
        reg_wr(2'd2, 16'(rl));
        reg_wr(2'd0, {8'h00, 1'b1, cpha, cpol, msb, 4'(wm1)});
        read_at(2'd0, v);
        check(sclk_out == cpol, "R7", "master idle clock level", sclk_out, cpol);
        arm_monitor(cpol, cpha);
        base = rx_cnt;
        reg_wr(2'd1, d);
        addr = 2'd0;
        @(negedge clk); #1;
        check(tx_irq && rdata[9], "R4", "tx_irq and busy one cycle after write",
              {tx_irq, rdata[9]}, 2'b11);
        wait_rx(base + 1);
        check(rx_irq && !rdata[9], "R5", "busy clears in rx_irq cycle", {rx_irq, rdata[9]}, 2'b10);
        mon_on = 0;
        read_at(2'd1, v);
        check((32'(v) & lowmask(w)) == (32'(d) & lowmask(w)), req, "received word right-aligned",
              32'(v) & lowmask(w), 32'(d) & lowmask(w));
        check(cap_n == w, "R1", "bits shifted per frame", cap_n, w);
        check(assemble(0, w, msb) == (32'(d) & lowmask(w)), msb ? "R2" : "R3",
              "serial bit stream and order", assemble(0, w, msb), 32'(d) & lowmask(w));
        check(gmin == rl + 1 && gmax == rl + 1, "R8", "half-period length",
              {gmin[15:0], gmax[15:0]}, {16'(rl + 1), 16'(rl + 1)});
    endtask

    task automatic t_chain();
        int base, tbase;
        logic [15:0] v;
        slave_mode = 1'b0;
        reg_wr(2'd2, 16'd1);
        reg_wr(2'd0, 16'h0097);
        arm_monitor(1'b0, 1'b0);
        base = rx_cnt; tbase = tx_cnt;
        reg_wr(2'd1, 16'h00A5);
        addr = 2'd0;
        @(negedge clk);
        busy_drop = 0; watch_until = base + 2; busy_watch = 1;
        reg_wr(2'd1, 16'h003C);
        addr = 2'd0;
        wait_rx(base + 2);
        busy_watch = 0; mon_on = 0;
        check(busy_drop == 0, "R6", "busy held across chained frames", busy_drop, 0);
        check(tx_cnt - tbase == 2, "R6", "two loads in chain", tx_cnt - tbase, 2);
        check(cap_n == 16, "R6", "bits across two frames", cap_n, 16);
        check(assemble(0, 8, 1) == 32'hA5 && assemble(8, 8, 1) == 32'h3C, "R6", "chained streams",
              {assemble(0, 8, 1)[7:0], assemble(8, 8, 1)[7:0]}, 16'hA53C);
        check(gmin == 2 && gmax == 2, "R6", "no gap at frame join",
              {gmin[15:0], gmax[15:0]}, {16'd2, 16'd2});
        read_at(2'd1, v);
        check(v[7:0] == 8'h3C, "R6", "receive register holds second word", v[7:0], 8'h3C);
    endtask

    task automatic t_collision();
        int base;
        logic [15:0] v;
        slave_mode = 1'b0;
        reg_wr(2'd2, 16'd3);
        reg_wr(2'd0, 16'h00E3);
        arm_monitor(1'b1, 1'b1);
        base = rx_cnt;
        reg_wr(2'd1, 16'h0009);
        reg_wr(2'd1, 16'h0006);
        reg_wr(2'd1, 16'h0003);
        read_at(2'd0, v);
        check(v[10] == 1'b1, "R10", "collision flag after overwrite", v[10], 1'b1);
        wait_rx(base + 2);
        mon_on = 0;
        check(assemble(0, 4, 0) == 32'h9 && assemble(4, 4, 0) == 32'h3, "R10",
              "overwritten word not sent", {assemble(0, 4, 0)[3:0], assemble(4, 4, 0)[3:0]}, 8'h93);
        reg_wr(2'd0, 16'h01E3);
        read_at(2'd0, v);
        check(v[10] == 1'b0 && v[7:0] == 8'hE3, "R10", "collision cleared, control kept",
              {v[10], v[7:0]}, {1'b0, 8'hE3});
    endtask

    task automatic t_busy_ro();
        logic [15:0] v;
        reg_wr(2'd0, 16'h0280);
        @(negedge clk);
        read_at(2'd0, v);
        check(v[9] == 1'b0 && v[7:0] == 8'h80, "R11", "busy not writable", {v[9], v[7:0]}, {1'b0, 8'h80});
    endtask

    task automatic t_slave(bit cpol, bit cpha, bit msb, int wm1, logic [15:0] dword, logic [15:0] ext);
        int w = fbits(wm1);
        int base;
        logic [31:0] got = '0;
        logic [15:0] v;
        slave_mode = 1'b1;
        sclk_drv = cpol;
        reg_wr(2'd0, {8'h00, 1'b0, cpha, cpol, msb, 4'(wm1)});
        repeat (4) @(negedge clk);
        base = rx_cnt;
        reg_wr(2'd1, dword);
        addr = 2'd0;
        repeat (30) @(negedge clk);
        #1;
        check(rdata[9] && rx_cnt == base && sclk_out == cpol, "R9", "slave waits for external clock",
              {rdata[9], 8'(rx_cnt - base), sclk_out}, {1'b1, 8'd0, cpol});
        for (int i = 0; i < w; i++) begin
            int bi = msb ? (w - 1 - i) : i;
            int oi = msb ? (w - 1 - i) : i;
            if (!cpha) begin
                sdi_drv = ext[bi];
                repeat (HALF_EXT) @(negedge clk);
                sclk_drv = ~cpol;
                got[oi] = sdo;
                repeat (HALF_EXT) @(negedge clk);
                sclk_drv = cpol;
            end else begin
                sclk_drv = ~cpol;
                sdi_drv = ext[bi];
                repeat (HALF_EXT) @(negedge clk);
                sclk_drv = cpol;
                got[oi] = sdo;
                repeat (HALF_EXT) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        read_at(2'd0, v);
        check(rx_cnt == base + 1 && !v[9], "R9", "slave frame completes, busy clear",
              {8'(rx_cnt - base), v[9]}, {8'd1, 1'b0});
        read_at(2'd1, v);
        check((32'(v) & lowmask(w)) == (32'(ext) & lowmask(w)), "R9", "slave received word",
              32'(v) & lowmask(w), 32'(ext) & lowmask(w));
        check(got == (32'(dword) & lowmask(w)), "R7", "slave transmitted word", got, 32'(dword) & lowmask(w));
        slave_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_master("R3", 1'b0, 1'b0, 1'b1, 7, 2, 16'hFFA5);
        t_master("R1", 1'b1, 1'b1, 1'b0, 15, 0, 16'hB3C1);
        t_master("R1", 1'b0, 1'b1, 1'b1, 1, 1, 16'hFFF2);
        t_master("R1", 1'b1, 1'b0, 1'b0, 0, 0, 16'h0001);
        t_master("R2", 1'b0, 1'b0, 1'b0, 10, 3, 16'h0635);
        t_chain();
        t_collision();
        t_busy_ro();
        t_slave(1'b0, 1'b0, 1'b1, 7, 16'h005A, 16'h00C3);
        t_slave(1'b1, 1'b1, 1'b0, 5, 16'hFF2D, 16'hAA13);
        check(wide_pulse == 0, "R5", "request pulses one cycle wide", wide_pulse, 0);
        summary();
    end
endmodule